// File: doc/BRIEF.md
# Serial ADC acquisition controller

This block is the host-side master for a serial successive-approximation converter that is controlled over a chip-select / clock / data link. For every transfer it lowers chip select, waits out the chip-select setup time, and clocks an 8-bit control word into the converter. The word holds the channel, the length code, the bit-order flag and the polarity flag. At the same time it receives the word that the converter produced for the previous transfer. After the last falling clock edge it releases chip select and waits for the converter's end-of-conversion flag to drop and rise again before it starts the next transfer.

The converter is pipelined: the word received in a transfer belongs to the channel, bit order and polarity sent one transfer earlier. The controller keeps that earlier setting and uses it to tag and decode each result. It throws away the first word after reset and the first word after a lost conversion. Channels come from a programmable list that is walked round robin. Each result leaves on a valid/ready stream as a 16-bit value (a 12-bit code, zero- or sign-extended) with a 4-bit channel tag. If the flag does not come back within a bounded number of system clocks, the controller pulses a timeout and restarts the link with a fresh chip-select cycle.

Top module: `adc_serial_master`

## Requirements
- R1: While reset is asserted, chip select is high, the serial clock is low, and the result valid and timeout outputs are low.
- R2: Chip select is low for at least CS_SETUP system clocks before the first rising serial clock edge of a transfer.
- R3: Each high phase and each low phase of the serial clock lasts at least CLK_DIV system clocks. The serial clock is low whenever chip select is high.
- R4: The control word is sent MSB first, one bit per serial clock, and each bit is set up during the low phase before its rising edge. Its bits [7:4] are the channel, [3:2] the length code, bit 1 the bit-order flag (1 = LSB first) and bit 0 the polarity flag (1 = bipolar).
- R5: A transfer has exactly 8 serial clocks for length code 01, 16 for code 11, and 12 for codes 00 and 10. The count follows the code sent in that same transfer.
- R6: After chip select rises, the next transfer starts only once end-of-conversion has been seen low and then high again. The one exception is the restart after a timeout.
- R7: Each result is tagged with the channel sent in the previous transfer. No result is produced for the first transfer after reset.
- R8: Channels are taken round robin from cfg_chan_list, with entry i at bits [4i+3:4i], over the first cfg_chan_count entries. A count of 0 is treated as 1, and a count above NCH is treated as NCH.
- R9: A 12-clock word is the 12-bit code. From a 16-clock word the four trailing pad bits are dropped. An 8-clock word forms code bits [11:4], and bits [3:0] read as zero.
- R10: The bit order used to assemble a received word is the flag sent in the previous transfer. With that flag at 1, the first bit received is the least significant bit of the word.
- R11: With the previous transfer's polarity flag at 1, res_data is the 12-bit code sign-extended from bit 11. With it at 0, the code is zero-extended.
- R12: If end-of-conversion has not risen EOC_TIMEOUT system clocks after chip select rose, eoc_timeout pulses for one clock and a new transfer starts. The result received in that new transfer is discarded.
- R13: A presented result keeps res_valid, res_data and res_chan stable until res_ready is high. No new transfer starts while a result is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 2 | Length code sent in each control word |
| cfg_lsb_first | input | 1 | Bit-order flag sent in each control word |
| cfg_bipolar | input | 1 | Polarity flag sent in each control word |
| cfg_chan_list | input | 4*NCH | Channel list, entry i at bits [4i+3:4i] |
| cfg_chan_count | input | clog2(NCH+1) | Number of list entries in use |
| adc_cs_n | output | 1 | Chip select to the converter, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_din | output | 1 | Control bit to the converter |
| adc_dout | input | 1 | Result bit from the converter |
| adc_eoc | input | 1 | End-of-conversion flag from the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result accepted by the consumer |
| res_data | output | 16 | Extended 12-bit result |
| res_chan | output | 4 | Channel the result belongs to |
| eoc_timeout | output | 1 | One-clock pulse when end-of-conversion is lost |

## Verification
The in-module assertions check the link timing on every cycle. They cover the chip-select setup before every rising edge, the minimum length of every clock phase, and the clock staying low outside chip select. They also check the rising-edge count against the length code latched for the transfer, that a transfer starts only after end-of-conversion is high or after a recovery, the single-cycle timeout pulse, and the stability of a result that is held back. The values themselves can only be shown by the bench scenarios, which run a behavioural converter model. These cover the pipelined channel tags, dropping the first result, walking the round-robin list, removing pad bits and truncating to 8 bits, the one-transfer lag when the bit order changes, sign extension, and recovery after a hung conversion.

// File: rtl/adc_serial_master.sv
module adc_serial_master #(
  parameter int CLK_DIV     = 13,
  parameter int CS_SETUP    = 143,
  parameter int EOC_TIMEOUT = 3000,
  parameter int NCH         = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 cfg_len,
  input  logic                       cfg_lsb_first,
  input  logic                       cfg_bipolar,
  input  logic [4*NCH-1:0]           cfg_chan_list,
  input  logic [$clog2(NCH+1)-1:0]   cfg_chan_count,
  output logic                       adc_cs_n,
  output logic                       adc_sclk,
  output logic                       adc_din,
  input  logic                       adc_dout,
  input  logic                       adc_eoc,
  output logic                       res_valid,
  input  logic                       res_ready,
  output logic [15:0]                res_data,
  output logic [3:0]                 res_chan,
  output logic                       eoc_timeout
);
  localparam int CW   = $clog2(NCH+1);
  localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CNTW = $clog2(EOC_TIMEOUT + CS_SETUP + CLK_DIV + 2);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_WLO, S_WHI} st_t;

  st_t             state;
  logic [CNTW-1:0] cnt;
  logic [4:0]      bitn;
  logic [7:0]      tx;
  logic [3:0]      p_chan;
  logic            p_lsb, p_bip, have_prev;
  logic [15:0]     sr_m;
  logic [11:0]     sr_l;
  logic [IW-1:0]   idx;

  wire [4:0] nbits = (tx[3:2] == 2'b01) ? 5'd8 : (tx[3:2] == 2'b11) ? 5'd16 : 5'd12;
  wire [CW-1:0] n_ch = (cfg_chan_count == '0) ? CW'(1) :
                       (int'(cfg_chan_count) > NCH) ? CW'(NCH) : cfg_chan_count;
  wire shifting = (state == S_SETUP) || (state == S_LOW) || (state == S_HIGH);
  assign adc_din = shifting && (bitn < 5'd8) && tx[3'd7 - bitn[2:0]];

  wire [11:0] v_m = (nbits == 5'd8) ? {sr_m[7:0], 4'b0} : (nbits == 5'd16) ? sr_m[15:4] : sr_m[11:0];
  wire [11:0] v_l = (nbits == 5'd8) ? {sr_l[11:4], 4'b0} : sr_l;
  wire [11:0] v12 = p_lsb ? v_l : v_m;
  wire [15:0] ext = p_bip ? {{4{v12[11]}}, v12} : {4'b0, v12};
  wire        phase_end = (cnt == CNTW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; bitn <= '0; tx <= '0; idx <= '0;
      adc_cs_n <= 1'b1; adc_sclk <= 1'b0;
      p_chan <= '0; p_lsb <= 1'b0; p_bip <= 1'b0; have_prev <= 1'b0;
      sr_m <= '0; sr_l <= '0;
      res_valid <= 1'b0; res_data <= '0; res_chan <= '0; eoc_timeout <= 1'b0;
    end else begin
      eoc_timeout <= 1'b0;
      if (res_valid && res_ready) res_valid <= 1'b0;
      case (state)
        S_IDLE: if (!res_valid) begin
          tx <= {cfg_chan_list[int'(idx)*4 +: 4], cfg_len, cfg_lsb_first, cfg_bipolar};
          idx <= (int'(idx) + 1 >= int'(n_ch)) ? '0 : idx + 1'b1;
          adc_cs_n <= 1'b0; cnt <= '0; bitn <= '0; sr_m <= '0; sr_l <= '0;
          state <= S_SETUP;
        end
        S_SETUP: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNTW'(CS_SETUP - 1)) begin cnt <= '0; state <= S_LOW; end
        end
        S_LOW: begin
          cnt <= cnt + 1'b1;
          if (phase_end) begin
            cnt <= '0; adc_sclk <= 1'b1; state <= S_HIGH;
            sr_m <= {sr_m[14:0], adc_dout};
            sr_l <= {adc_dout, sr_l[11:1]};
          end
        end
        S_HIGH: begin
          cnt <= cnt + 1'b1;
          if (phase_end) begin
            cnt <= '0; adc_sclk <= 1'b0;
            if (bitn == nbits - 5'd1) begin
              adc_cs_n <= 1'b1; state <= S_WLO;
              if (have_prev) begin res_valid <= 1'b1; res_data <= ext; res_chan <= p_chan; end
              p_chan <= tx[7:4]; p_lsb <= tx[1]; p_bip <= tx[0]; have_prev <= 1'b1;
            end else begin
              bitn <= bitn + 5'd1; state <= S_LOW;
            end
          end
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (state == S_WLO && !adc_eoc) state <= S_WHI;
          else if (state == S_WHI && adc_eoc) begin state <= S_IDLE; cnt <= '0; end
          else if (cnt >= CNTW'(EOC_TIMEOUT - 1)) begin
            eoc_timeout <= 1'b1; have_prev <= 1'b0; state <= S_IDLE; cnt <= '0;
          end
        end
      endcase
    end
  end

  logic [CNTW-1:0] cs_age, ph_age;
  logic [4:0]      rises;
  logic            sclk_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_age <= '0; ph_age <= '0; rises <= '0; sclk_q <= 1'b0;
    end else begin
      sclk_q <= adc_sclk;
      cs_age <= adc_cs_n ? '0 : ((cs_age != '1) ? cs_age + 1'b1 : cs_age);
      ph_age <= (adc_sclk != sclk_q) ? CNTW'(1) : ((ph_age != '1) ? ph_age + 1'b1 : ph_age);
      rises  <= adc_cs_n ? '0 : rises + 5'(adc_sclk && !sclk_q);
    end
  end

  assert_cs_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_sclk) |-> cs_age >= CNTW'(CS_SETUP));
  assert_high_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_sclk) |-> ph_age >= CNTW'(CLK_DIV));
  assert_low_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_sclk) |-> ph_age >= CNTW'(CLK_DIV));
  assert_idle_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);
  assert_clock_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |-> rises == nbits);
  assert_wait_eoc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> $past(adc_eoc) || !have_prev);
  assert_timeout_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_timeout |=> !eoc_timeout && !adc_sclk);
  assert_hold_result_R13: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_chan));
  assert_no_start_pending_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> !$past(res_valid));
endmodule

// File: tb/tb_adc_serial_master.sv
module tb_adc_serial_master;
  localparam int PER = 10;
  localparam int CLK_DIV = 3, CS_SETUP = 7, EOC_TIMEOUT = 400, NCH = 4, CONV = 1500;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_len = 0;
  logic cfg_lsb_first = 0, cfg_bipolar = 0;
  logic [4*NCH-1:0] cfg_chan_list = 0;
  logic [2:0] cfg_chan_count = 1;
  logic adc_cs_n, adc_sclk, adc_din, adc_dout = 0, adc_eoc = 1;
  logic res_valid, res_ready = 1;
  logic [15:0] res_data;
  logic [3:0] res_chan;
  logic eoc_timeout;

  adc_serial_master #(.CLK_DIV(CLK_DIV), .CS_SETUP(CS_SETUP), .EOC_TIMEOUT(EOC_TIMEOUT), .NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_lsb_first(cfg_lsb_first),
    .cfg_bipolar(cfg_bipolar), .cfg_chan_list(cfg_chan_list), .cfg_chan_count(cfg_chan_count),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_din(adc_din), .adc_dout(adc_dout),
    .adc_eoc(adc_eoc), .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_chan(res_chan), .eoc_timeout(eoc_timeout));

  always #(PER/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] val(input logic [3:0] ch);
    return {ch, ~ch, ch ^ 4'h9};
  endfunction
  function automatic int nlen(input logic [1:0] c);
    return (c == 2'b01) ? 8 : (c == 2'b11) ? 16 : 12;
  endfunction
  function automatic logic [15:0] expv(input logic [3:0] ch, input logic bip, input logic [1:0] len);
    logic [11:0] v = val(ch);
    if (len == 2'b01) v = {v[11:4], 4'b0};
    return bip ? {{4{v[11]}}, v} : {4'b0, v};
  endfunction

  // converter model
  logic [11:0] m_r = 0; logic m_lsb = 0; logic [1:0] m_len = 0;
  logic [7:0] m_rx = 0, conv_word = 0;
  int m_k = 0, m_rises = 0, gen = 0, xfers = 0, early_start = 0;
  logic hang = 0, allow_abort = 0, in_xfer = 0;
  longint t_cs = 0, t_rise = 0, t_fall = 0, setup_min, hi_min, lo_min;
  int xr[64]; logic [7:0] xw[64];
  event conv_go;

  function automatic logic m_bit(input int k);
    int n = nlen(m_len);
    logic [15:0] w = (n == 16) ? {m_r, 4'b0} : (n == 8) ? {8'b0, m_r[11:4]} : {4'b0, m_r};
    if (k >= n) return 1'b0;
    return w[m_lsb ? k : n - 1 - k];
  endfunction

  always @(negedge adc_cs_n) begin
    if (!adc_eoc && !allow_abort) early_start++;
    gen++; adc_eoc = 1; m_k = 0; m_rises = 0; in_xfer = 1; t_cs = $time;
    adc_dout = m_bit(0);
  end
  always @(posedge adc_cs_n) if (in_xfer) begin
    in_xfer = 0; xr[xfers % 64] = m_rises; xw[xfers % 64] = m_rx; xfers++;
  end
  always @(posedge adc_sclk) begin
    if (m_rises == 0) begin if ($time - t_cs < setup_min) setup_min = $time - t_cs; end
    else if ($time - t_fall < lo_min) lo_min = $time - t_fall;
    if (m_rises < 8) m_rx = {m_rx[6:0], adc_din};
    m_rises++; t_rise = $time;
  end
  always @(negedge adc_sclk) begin
    if ($time - t_rise < hi_min) hi_min = $time - t_rise;
    t_fall = $time; m_k++; adc_dout = m_bit(m_k);
    if (m_rises == nlen(m_rx[3:2])) begin conv_word = m_rx; ->conv_go; end
  end
  always begin
    int g, t;
    @(conv_go);
    g = gen;
    #50 if (gen == g) adc_eoc = 0;
    t = 0;
    while ((t < CONV || hang) && gen == g) begin #10; t += 10; end
    if (gen == g) begin
      m_r = val(conv_word[7:4]); m_len = conv_word[3:2]; m_lsb = conv_word[1]; adc_eoc = 1;
    end
  end

  // result and timeout monitors
  int nres = 0, tmo_cnt = 0, tmo_run = 0, tmo_max = 0, xfers_at_tmo = -1;
  logic [15:0] rd[64]; logic [3:0] rc[64];
  always @(negedge clk) if (rst_n) begin
    if (res_valid && res_ready) begin rd[nres % 64] = res_data; rc[nres % 64] = res_chan; nres++; end
    if (eoc_timeout) begin
      if (tmo_run == 0) begin tmo_cnt++; if (xfers_at_tmo < 0) xfers_at_tmo = xfers; end
      tmo_run++; if (tmo_run > tmo_max) tmo_max = tmo_run;
    end else tmo_run = 0;
  end

  task automatic clear_stats;
    nres = 0; xfers = 0; early_start = 0; tmo_cnt = 0; tmo_run = 0; tmo_max = 0; xfers_at_tmo = -1;
    setup_min = 1000000; hi_min = 1000000; lo_min = 1000000; in_xfer = 0;
  endtask
  task automatic do_reset;
    rst_n = 0; gen++; hang = 0; allow_abort = 0; adc_eoc = 1; m_r = 0; m_lsb = 0; m_len = 0;
    repeat (3) @(negedge clk);
    clear_stats();
    rst_n = 1;
  endtask
  task automatic wait_xfers(input int n);
    while (xfers < n) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1", "cs_n in reset", adc_cs_n, 1);
    check("R1", "sclk in reset", adc_sclk, 0);
    check("R1", "valid in reset", res_valid, 0);
    check("R1", "timeout in reset", eoc_timeout, 0);
  endtask

  task automatic t_basic;
    logic [3:0] seq[5] = '{4'd5, 4'd2, 4'd9, 4'd5, 4'd2};
    cfg_chan_list = {4'd12, 4'd9, 4'd2, 4'd5}; cfg_chan_count = 3;
    cfg_len = 2'b00; cfg_lsb_first = 0; cfg_bipolar = 0; res_ready = 1;
    do_reset(); wait_xfers(5);
    check("R7", "result count, first dropped", nres, 4);
    for (int i = 0; i < 5; i++) begin
      check("R4", "control word", xw[i], {seq[i], 4'b0000});
      check("R8", "round robin channel", xw[i][7:4], seq[i]);
      check("R5", "12-clock transfer", xr[i], 12);
    end
    for (int i = 0; i < 4; i++) begin
      check("R7", "result channel tag", rc[i], seq[i]);
      check("R9", "12-bit value", rd[i], expv(seq[i], 0, 2'b00));
    end
    check("R2", "cs setup long enough", 32'(setup_min >= CS_SETUP * PER), 1);
    check("R3", "high phase long enough", 32'(hi_min >= CLK_DIV * PER), 1);
    check("R3", "low phase long enough", 32'(lo_min >= CLK_DIV * PER), 1);
    check("R6", "no start before eoc", early_start, 0);
  endtask

  task automatic t_len16_bip;
    cfg_chan_list = {4'd0, 4'd0, 4'd0, 4'd9}; cfg_chan_count = 0;
    cfg_len = 2'b11; cfg_lsb_first = 0; cfg_bipolar = 1;
    do_reset(); wait_xfers(3);
    check("R7", "result count", nres, 2);
    check("R5", "16-clock transfer", xr[1], 16);
    check("R4", "control word 16 bip", xw[1], 8'h9D);
    check("R8", "count 0 acts as 1", rc[1], 9);
    check("R11", "sign-extended 16-bit", rd[0], 16'hF960);
    check("R9", "pads dropped", rd[1], expv(9, 1, 2'b11));
  endtask

  task automatic t_len8;
    cfg_chan_list = {4'd0, 4'd0, 4'd0, 4'd12}; cfg_chan_count = 1;
    cfg_len = 2'b01; cfg_lsb_first = 0; cfg_bipolar = 0;
    do_reset(); wait_xfers(3);
    check("R5", "8-clock transfer", xr[2], 8);
    check("R9", "8-bit value", rd[0], 16'h0C30);
    check("R11", "unipolar zero-extended", rd[1], 16'h0C30);
  endtask

  task automatic t_lsb;
    logic [3:0] seq[3] = '{4'd6, 4'd10, 4'd6};
    cfg_chan_list = {4'd0, 4'd0, 4'd10, 4'd6}; cfg_chan_count = 2;
    cfg_len = 2'b00; cfg_lsb_first = 1; cfg_bipolar = 1;
    do_reset(); wait_xfers(4);
    check("R7", "result count", nres, 3);
    for (int i = 0; i < 3; i++) begin
      check("R10", "LSB-first value", rd[i], expv(seq[i], 1, 2'b00));
      check("R8", "two-entry list tag", rc[i], seq[i]);
    end
  endtask

  task automatic t_order_change;
    cfg_chan_list = {4'd0, 4'd0, 4'd0, 4'd3}; cfg_chan_count = 1;
    cfg_len = 2'b00; cfg_lsb_first = 0; cfg_bipolar = 0;
    do_reset(); wait_xfers(1);
    cfg_lsb_first = 1;
    wait_xfers(4);
    check("R10", "result count", nres, 3);
    check("R10", "old order kept one transfer", rd[0], 16'h03CA);
    check("R10", "new order after lag", rd[1], 16'h03CA);
    check("R10", "new order steady", rd[2], 16'h03CA);
  endtask

  task automatic t_timeout;
    int guard = 0;
    cfg_chan_list = {4'd0, 4'd0, 4'd0, 4'd4}; cfg_chan_count = 1;
    cfg_len = 2'b00; cfg_lsb_first = 0; cfg_bipolar = 0;
    do_reset(); hang = 1; allow_abort = 1;
    while (tmo_cnt == 0 && guard < 5000) begin @(negedge clk); guard++; end
    hang = 0;
    wait_xfers(3);
    check("R12", "one timeout", tmo_cnt, 1);
    check("R12", "pulse width", tmo_max, 1);
    check("R12", "no start before timeout", xfers_at_tmo, 1);
    check("R12", "restart result dropped", nres, 1);
    check("R12", "result after recovery", rd[0], 16'h04BD);
    check("R7", "tag after recovery", rc[0], 4);
    allow_abort = 0;
  endtask

  task automatic t_backpressure;
    int x0; logic [15:0] d0;
    cfg_chan_list = {4'd0, 4'd0, 4'd0, 4'd7}; cfg_chan_count = 1;
    cfg_len = 2'b00; cfg_lsb_first = 0; cfg_bipolar = 0; res_ready = 0;
    do_reset();
    while (!res_valid) @(negedge clk);
    d0 = res_data; x0 = xfers;
    repeat (800) @(negedge clk);
    check("R13", "valid held", res_valid, 1);
    check("R13", "data held", res_data, d0);
    check("R13", "no new transfer", xfers, x0);
    check("R13", "cs idle while pending", adc_cs_n, 1);
    check("R13", "no timeout while stalled", tmo_cnt, 0);
    res_ready = 1;
    wait_xfers(x0 + 2);
    check("R13", "pending result delivered", rd[0], expv(7, 0, 2'b00));
    check("R13", "pending tag delivered", rc[0], 7);
    check("R13", "flow resumes", nres, 3);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(PER * 190000);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    clear_stats();
    t_reset();
    t_basic();
    t_len16_bip();
    t_len8();
    t_lsb();
    t_order_change();
    t_timeout();
    t_backpressure();
    finish_run();
  end
endmodule